// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration

A synchronous two-port memory with a left side and a right side. Each side has its own enable, output enable, write strobe, per-byte lane selects, address and data. Either side can read or write any word on any cycle. Each word is split into byte lanes. With the strobe high, the lanes whose select bit is set are written and the remaining lanes are read in the same access. Read data appears one cycle after the access, and a lane that was not read shows zero with its valid bit low.

When both enabled sides point at one address, a flag that is active low tells one side that it lost. The side that was already holding the address keeps it. If both sides arrive on the same cycle, the left side is preferred. The losing side's writes are dropped. A mode input turns the block into a follower: the two flags then come from outside pins, pass straight through, and block writes in the same way, and the internal arbiter no longer takes part.

Top module: `dpram_arb`

## Requirements
- R1: Each side reads or writes any address on any cycle, independently of the other side. If both sides write the same lane of the same address on one cycle without being blocked, the left value is stored.
- R2: Lane b covers data bits [8b+7:8b]. When enable and strobe are high, the lanes whose select bit is 1 are written and the lanes whose select bit is 0 are read. When the strobe is low, the lanes whose select bit is 1 are read.
- R3: Read data is returned on the cycle after the access and holds the content from before that cycle's writes.
- R4: A lane's valid bit is 1 only if that lane was read with both enable and output enable high on the previous cycle. A lane whose valid bit is 0 returns zero.
- R5: A side with its enable low performs no access, and in master mode both busy flags stay high.
- R6: In master mode (mode input 0), when both sides are enabled at equal addresses exactly one busy flag is low. The two flags are never low together.
- R7: If one side held the same address enabled on the previous cycle and the other side did not, the side that held it wins. The other side's flag goes low.
- R8: If neither side held the colliding address on the previous cycle, the left side wins and the right flag goes low. A collision that continues at an unchanged address keeps its winner.
- R9: A busy flag returns high on the same cycle in which the addresses differ or either side is disabled.
- R10: A write from a side whose busy flag is low leaves memory unchanged.
- R11: In slave mode (mode input 1), each busy output equals its external input, and a low external input blocks that side's writes. No internal arbitration takes place.
- R12: A read that collides with the other side's unblocked write to that lane returns either the old or the new lane value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_slave | input | 1 | 0: internal arbitration, 1: busy taken from external inputs |
| l_en | input | 1 | Left side enable |
| l_oe | input | 1 | Left output enable |
| l_wr | input | 1 | Left write strobe |
| l_lane | input | LANES | Left lane selects |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | LANES*LANE_W | Left write data |
| l_rdata | output | LANES*LANE_W | Left read data |
| l_rvalid | output | LANES | Left per-lane read valid |
| l_busy_n | output | 1 | Left busy flag, active low |
| ext_busy_l_n | input | 1 | External left busy used in slave mode |
| r_en | input | 1 | Right side enable |
| r_oe | input | 1 | Right output enable |
| r_wr | input | 1 | Right write strobe |
| r_lane | input | LANES | Right lane selects |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | LANES*LANE_W | Right write data |
| r_rdata | output | LANES*LANE_W | Right read data |
| r_rvalid | output | LANES | Right per-lane read valid |
| r_busy_n | output | 1 | Right busy flag, active low |
| ext_busy_r_n | input | 1 | External right busy used in slave mode |

## Verification
The hardest case to reach is a collision whose winner is set by history, because the outcome depends on which side was already parked on the address one cycle earlier. The stimulus parks one side on an address for a cycle and then brings the other side onto it, once from each direction. It then holds the collision for a further cycle to confirm the winner is kept, and moves one side away to confirm the flag releases. A long random run confined to four addresses then produces many arrivals, departures and simultaneous arrivals in both modes. A behavioural model judges every cycle and accepts either value for reads that collide with a write.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   typedef enum logic {
      OWN_LEFT  = 1'b0,
      OWN_RIGHT = 1'b1
   } owner_e;

   // a lane is read when selected with a low strobe, or unselected with a high strobe
   function automatic logic lane_reads(logic en, logic oe, logic wr, logic sel);
      return en & oe & (wr ? ~sel : sel);
   endfunction

   function automatic logic lane_writes(logic en, logic wr, logic sel, logic blocked);
      return en & wr & sel & ~blocked;
   endfunction

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_slave,
   input  logic              l_en,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              ext_busy_l_n,
   input  logic              ext_busy_r_n,
   output logic              busy_l_n,
   output logic              busy_r_n
);

   logic              l_en_q, r_en_q, hit_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   owner_e            owner_q, owner_d;
   logic              hit, l_held, r_held, carry;

   always_comb begin
      hit    = l_en & r_en & (l_addr == r_addr);
      l_held = l_en_q & (l_addr_q == l_addr);
      r_held = r_en_q & (r_addr_q == r_addr);
      carry  = hit & hit_q & l_held & r_held;
      if (carry)
         owner_d = owner_q;
      else if (r_held & ~l_held)
         owner_d = OWN_RIGHT;
      else
         owner_d = OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_en_q   <= 1'b0;
         r_en_q   <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
         hit_q    <= 1'b0;
         owner_q  <= OWN_LEFT;
      end else begin
         l_en_q   <= l_en;
         r_en_q   <= r_en;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         hit_q    <= hit;
         owner_q  <= owner_d;
      end
   end

   always_comb begin
      if (mode_slave) begin
         busy_l_n = ext_busy_l_n;
         busy_r_n = ext_busy_r_n;
      end else begin
         busy_l_n = ~(hit & (owner_d == OWN_RIGHT));
         busy_r_n = ~(hit & (owner_d == OWN_LEFT));
      end
   end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       a_addr,
   input  logic [ADDR_W-1:0]       b_addr,
   input  logic [LANES-1:0]        a_we,
   input  logic [LANES-1:0]        b_we,
   input  logic [LANES*LANE_W-1:0] a_wdata,
   input  logic [LANES*LANE_W-1:0] b_wdata,
   output logic [LANES*LANE_W-1:0] a_rdata,
   output logic [LANES*LANE_W-1:0] b_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] a_q, b_q;

      // side b first so that side a wins a same-cycle write to one word
      always_ff @(posedge clk) begin
         if (b_we[g]) bank[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
         if (a_we[g]) bank[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
         a_q <= bank[a_addr];
         b_q <= bank[b_addr];
      end

      assign a_rdata[g*LANE_W +: LANE_W] = a_q;
      assign b_rdata[g*LANE_W +: LANE_W] = b_q;
   end

endmodule

// File: rtl/dpram_port.sv
module dpram_port
   import dpram_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    oe,
   input  logic                    wr,
   input  logic [LANES-1:0]        lane,
   input  logic                    blocked,
   output logic [LANES-1:0]        we,
   input  logic [LANES*LANE_W-1:0] raw,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic [LANES-1:0]        rvalid
);

   logic [LANES-1:0] rsel;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign we[g]   = lane_writes(en, wr, lane[g], blocked);
      assign rsel[g] = lane_reads(en, oe, wr, lane[g]);
      assign rdata[g*LANE_W +: LANE_W] = rvalid[g] ? raw[g*LANE_W +: LANE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= '0;
      else        rvalid <= rsel;
   end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_slave,
   input  logic                    l_en,
   input  logic                    l_oe,
   input  logic                    l_wr,
   input  logic [LANES-1:0]        l_lane,
   input  logic [ADDR_W-1:0]       l_addr,
   input  logic [LANES*LANE_W-1:0] l_wdata,
   output logic [LANES*LANE_W-1:0] l_rdata,
   output logic [LANES-1:0]        l_rvalid,
   output logic                    l_busy_n,
   input  logic                    ext_busy_l_n,
   input  logic                    r_en,
   input  logic                    r_oe,
   input  logic                    r_wr,
   input  logic [LANES-1:0]        r_lane,
   input  logic [ADDR_W-1:0]       r_addr,
   input  logic [LANES*LANE_W-1:0] r_wdata,
   output logic [LANES*LANE_W-1:0] r_rdata,
   output logic [LANES-1:0]        r_rvalid,
   output logic                    r_busy_n,
   input  logic                    ext_busy_r_n
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   logic [LANES-1:0]  l_we, r_we;
   logic [DATA_W-1:0] l_raw, r_raw;

   dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave),
      .l_en(l_en), .r_en(r_en), .l_addr(l_addr), .r_addr(r_addr),
      .ext_busy_l_n(ext_busy_l_n), .ext_busy_r_n(ext_busy_r_n),
      .busy_l_n(l_busy_n), .busy_r_n(r_busy_n)
   );

   dpram_port #(.LANES(LANES), .LANE_W(LANE_W)) u_lport (
      .clk(clk), .rst_n(rst_n), .en(l_en), .oe(l_oe), .wr(l_wr),
      .lane(l_lane), .blocked(~l_busy_n), .we(l_we), .raw(l_raw),
      .rdata(l_rdata), .rvalid(l_rvalid)
   );

   dpram_port #(.LANES(LANES), .LANE_W(LANE_W)) u_rport (
      .clk(clk), .rst_n(rst_n), .en(r_en), .oe(r_oe), .wr(r_wr),
      .lane(r_lane), .blocked(~r_busy_n), .we(r_we), .raw(r_raw),
      .rdata(r_rdata), .rvalid(r_rvalid)
   );

   dpram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk(clk), .a_addr(l_addr), .b_addr(r_addr), .a_we(l_we), .b_we(r_we),
      .a_wdata(l_wdata), .b_wdata(r_wdata), .a_rdata(l_raw), .b_rdata(r_raw)
   );

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_slave,
   input logic              l_en,
   input logic              l_oe,
   input logic              l_wr,
   input logic [LANES-1:0]  l_lane,
   input logic [ADDR_W-1:0] l_addr,
   input logic [LANES-1:0]  l_rvalid,
   input logic              l_busy_n,
   input logic              ext_busy_l_n,
   input logic              r_en,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic [LANES-1:0]  r_rvalid,
   input logic              r_busy_n,
   input logic              ext_busy_r_n
);

   logic same;
   assign same = l_en & r_en & (l_addr == r_addr);

   a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_slave |-> (l_busy_n | r_busy_n));

   a_r6_one_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && same) |-> (l_busy_n ^ r_busy_n));

   a_r5_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && (!l_en || !r_en)) |-> (l_busy_n && r_busy_n));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && l_addr != r_addr) |-> (l_busy_n && r_busy_n));

   a_r8_keep_winner: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && same && !r_busy_n) |=>
      ((!mode_slave && same && $stable(l_addr) && $stable(r_addr)) |-> !r_busy_n));

   a_r11_follow: assert property (@(posedge clk) disable iff (!rst_n)
      mode_slave |-> (l_busy_n == ext_busy_l_n && r_busy_n == ext_busy_r_n));

   a_r4_left_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en || !l_oe) |=> (l_rvalid == '0));

   a_r4_right_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_en || !r_oe) |=> (r_rvalid == '0));

   a_r2_no_read_of_written: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en && l_wr) |=> ((l_rvalid & $past(l_lane)) == '0));

endmodule

bind dpram_arb dpram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave),
   .l_en(l_en), .l_oe(l_oe), .l_wr(l_wr), .l_lane(l_lane), .l_addr(l_addr),
   .l_rvalid(l_rvalid), .l_busy_n(l_busy_n), .ext_busy_l_n(ext_busy_l_n),
   .r_en(r_en), .r_oe(r_oe), .r_addr(r_addr),
   .r_rvalid(r_rvalid), .r_busy_n(r_busy_n), .ext_busy_r_n(ext_busy_r_n)
);

// File: tb/sim_dpram_arb.sv
module sim_dpram_arb;
   localparam int AW = 6;
   localparam int LN = 2;
   localparam int LW = 8;
   localparam int DW = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, mode_slave, ext_l, ext_r;
   logic l_en, l_oe, l_wr, r_en, r_oe, r_wr;
   logic [LN-1:0] l_lane, r_lane, l_rvalid, r_rvalid;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
   logic l_busy_n, r_busy_n;

   dpram_arb #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave),
      .l_en(l_en), .l_oe(l_oe), .l_wr(l_wr), .l_lane(l_lane), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
      .ext_busy_l_n(ext_l),
      .r_en(r_en), .r_oe(r_oe), .r_wr(r_wr), .r_lane(r_lane), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_n(r_busy_n),
      .ext_busy_r_n(ext_r)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int mm [DEPTH];
   bit lq_en = 0, rq_en = 0, mq = 0, oq = 0;
   int lq_a = 0, rq_a = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_either(input string tag, input string what, input int act,
                             input int a, input int b);
      checks++;
      if (act != a && act != b) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h or %0h", tag, what, act, a, b);
      end
   endtask

   task automatic drive_l(input bit en, input bit oe, input bit wr, input int lane,
                          input int addr, input int data);
      l_en = en; l_oe = oe; l_wr = wr; l_lane = LN'(lane);
      l_addr = AW'(addr); l_wdata = DW'(data);
   endtask

   task automatic drive_r(input bit en, input bit oe, input bit wr, input int lane,
                          input int addr, input int data);
      r_en = en; r_oe = oe; r_wr = wr; r_lane = LN'(lane);
      r_addr = AW'(addr); r_wdata = DW'(data);
   endtask

   function automatic int lane_of(input int v, input int b);
      return (v >> (b * LW)) & ((1 << LW) - 1);
   endfunction

   // one clock: inputs already applied after a falling edge
   task automatic step(input string tag);
      bit hit, lh, rh, carry, own_r, bl, br;
      bit lwe [LN], rwe [LN], lrd [LN], rrd [LN], leit [LN], reit [LN];
      int lold [LN], rold [LN], lnew [LN], rnew [LN];
      int la, ra, lv, rv;
      #1;
      la = int'(l_addr); ra = int'(r_addr);
      hit   = l_en && r_en && (la == ra);
      lh    = lq_en && (lq_a == la);
      rh    = rq_en && (rq_a == ra);
      carry = hit && mq && lh && rh;
      own_r = carry ? oq : (rh && !lh);
      if (mode_slave) begin bl = !ext_l; br = !ext_r; end
      else begin bl = hit && own_r; br = hit && !own_r; end
      chk(tag, "l_busy_n", int'(l_busy_n), int'(!bl));
      chk(tag, "r_busy_n", int'(r_busy_n), int'(!br));
      for (int b = 0; b < LN; b++) begin
         lwe[b] = l_en && l_wr && l_lane[b] && !bl;
         rwe[b] = r_en && r_wr && r_lane[b] && !br;
         lrd[b] = l_en && l_oe && (l_wr ? !l_lane[b] : l_lane[b]);
         rrd[b] = r_en && r_oe && (r_wr ? !r_lane[b] : r_lane[b]);
         lold[b] = lane_of(mm[la], b);
         rold[b] = lane_of(mm[ra], b);
         leit[b] = rwe[b] && (ra == la);
         reit[b] = lwe[b] && (ra == la);
         lnew[b] = lane_of(int'(r_wdata), b);
         rnew[b] = lane_of(int'(l_wdata), b);
      end
      @(posedge clk);
      for (int b = 0; b < LN; b++) begin
         int m;
         m = ((1 << LW) - 1) << (b * LW);
         if (rwe[b]) mm[ra] = (mm[ra] & ~m) | (int'(r_wdata) & m);
         if (lwe[b]) mm[la] = (mm[la] & ~m) | (int'(l_wdata) & m);
      end
      lq_en = l_en; rq_en = r_en; lq_a = la; rq_a = ra; mq = hit; oq = own_r;
      #1;
      lv = 0; rv = 0;
      for (int b = 0; b < LN; b++) begin
         lv |= int'(lrd[b]) << b;
         rv |= int'(rrd[b]) << b;
      end
      chk(tag, "l_rvalid", int'(l_rvalid), lv);
      chk(tag, "r_rvalid", int'(r_rvalid), rv);
      for (int b = 0; b < LN; b++) begin
         if (!lrd[b]) chk(tag, "l_rdata lane", lane_of(int'(l_rdata), b), 0);
         else if (leit[b]) chk_either(tag, "l_rdata lane", lane_of(int'(l_rdata), b), lold[b], lnew[b]);
         else chk(tag, "l_rdata lane", lane_of(int'(l_rdata), b), lold[b]);
         if (!rrd[b]) chk(tag, "r_rdata lane", lane_of(int'(r_rdata), b), 0);
         else if (reit[b]) chk_either(tag, "r_rdata lane", lane_of(int'(r_rdata), b), rold[b], rnew[b]);
         else chk(tag, "r_rdata lane", lane_of(int'(r_rdata), b), rold[b]);
      end
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode_slave = 1'b0; ext_l = 1'b1; ext_r = 1'b1;
      drive_l(0, 0, 0, 0, 0, 0);
      drive_r(0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R4", "reset l_rvalid", int'(l_rvalid), 0);
      chk("R5", "reset busy", int'({l_busy_n, r_busy_n}), 3);
      @(negedge clk);

      // R1: fill memory, both sides writing distinct words each cycle
      for (int i = 0; i < DEPTH / 2; i++) begin
         drive_l(1, 0, 1, 3, i, (i * 16'h0321 + 16'h1111) & 16'hFFFF);
         drive_r(1, 0, 1, 3, i + DEPTH / 2, ((i + 32) * 16'h0321 + 16'h1111) & 16'hFFFF);
         step("R1");
      end
      // R3: independent reads
      drive_l(1, 1, 0, 3, 3, 0); drive_r(1, 1, 0, 3, 40, 0); step("R3");
      drive_l(1, 1, 1, 1, 5, 16'h7777); drive_r(1, 1, 0, 3, 5, 0); step("R12");
      // R2: write low lane, read high lane in one access, then read back
      drive_r(0, 0, 0, 0, 0, 0);
      drive_l(1, 1, 1, 1, 7, 16'hBEEF); step("R2");
      drive_l(1, 1, 0, 2, 7, 0); step("R2");
      drive_l(1, 1, 0, 1, 7, 0); step("R2");
      // R4: output enable low, then enable low
      drive_l(1, 0, 0, 3, 7, 0); step("R4");
      drive_l(0, 1, 0, 3, 7, 0); step("R4");
      // R5: disabled side at same address as a writer
      drive_l(0, 1, 1, 3, 9, 16'hFFFF); drive_r(1, 1, 1, 3, 9, 16'h0909); step("R5");
      drive_l(1, 1, 0, 3, 9, 0); drive_r(0, 0, 0, 0, 0, 0); step("R5");
      // R8: simultaneous arrival, held, then right leaves
      drive_l(0, 0, 0, 0, 0, 0); step("R8");
      drive_l(1, 1, 1, 3, 12, 16'hAAAA); drive_r(1, 1, 1, 3, 12, 16'h5555); step("R8");
      step("R8");
      drive_r(1, 1, 1, 3, 13, 16'h5151); step("R9");
      drive_l(1, 1, 0, 3, 12, 0); drive_r(1, 1, 0, 3, 13, 0); step("R10");
      // R7: left parks first, right arrives with a write
      drive_r(0, 0, 0, 0, 0, 0); drive_l(1, 1, 0, 3, 20, 0); step("R7");
      drive_r(1, 1, 1, 3, 20, 16'hDEAD); step("R10");
      drive_l(0, 0, 0, 0, 0, 0); drive_r(1, 1, 0, 3, 20, 0); step("R10");
      // R7: right parks first, left arrives with a write
      drive_r(0, 0, 0, 0, 0, 0); step("R7");
      drive_r(1, 1, 1, 3, 21, 16'h1357); step("R7");
      drive_l(1, 1, 1, 3, 21, 16'h2468); step("R7");
      drive_r(0, 0, 0, 0, 0, 0); drive_l(1, 1, 0, 3, 21, 0); step("R10");
      // R12: winner writes while loser reads
      drive_l(1, 1, 1, 3, 22, 16'h0F0F); step("R12");
      drive_l(1, 1, 1, 3, 22, 16'hF0F0); drive_r(1, 1, 0, 3, 22, 0); step("R12");
      // R11: slave mode
      drive_l(0, 0, 0, 0, 0, 0); drive_r(0, 0, 0, 0, 0, 0); step("R11");
      mode_slave = 1'b1; ext_l = 1'b0; ext_r = 1'b1;
      drive_l(1, 1, 1, 3, 30, 16'h3030); drive_r(1, 1, 1, 3, 31, 16'h3131); step("R11");
      ext_l = 1'b1; ext_r = 1'b0;
      drive_l(1, 1, 0, 3, 30, 0); drive_r(1, 1, 1, 3, 30, 16'h9999); step("R11");
      ext_r = 1'b1;
      drive_l(1, 1, 1, 3, 31, 16'hC0DE); drive_r(1, 1, 1, 3, 31, 16'h0BAD); step("R1");
      drive_l(1, 1, 0, 3, 31, 0); drive_r(1, 1, 0, 3, 30, 0); step("R11");
      // R6: random traffic over four addresses in both modes
      for (int i = 0; i < 600; i++) begin
         if (i % 60 == 0) mode_slave = (i / 60) % 3 == 2;
         ext_l = ($urandom % 4) != 0;
         ext_r = ($urandom % 4) != 0;
         if (($urandom % 3) != 0)
            drive_l(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 2,
                    $urandom % 4, $urandom % 4, $urandom % 65536);
         if (($urandom % 3) != 0)
            drive_r(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 2,
                    $urandom % 4, $urandom % 4, $urandom % 65536);
         step("R6");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule